// File: doc/BRIEF.md
# Paired-Core Memory Slot Arbiter

This block decides, every clock cycle, which of sixteen cores may use a single shared memory port. A slot counter steps through sixteen slots in a fixed loop. By default slot `s` belongs to core `s`, so each core sees a service interval of sixteen cycles that does not depend on anything the other cores do.

Two optional features let spare cores help a busy one. First, cores `p` and `p+8` may pool their two slots, which lie eight cycles apart. Either the lower core takes both slots outright, or the lower core has first claim and the upper core uses whatever the lower one leaves. Second, a slot whose owner is idle can be lent to a borrowing core: either always core 0, or core 0 on even slots and core 8 on odd slots. Configuration arrives on a write strobe and is held in staging registers. It reaches the arbiter only when the slot counter wraps, so every rotation runs under one consistent setting.

The grant for the slot in cycle `k` is registered and appears on the outputs in cycle `k+1`.

Top module: `pair_slot_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, the grant outputs are all zero. The slot counter starts at 0 with pairing off and borrowing off.
- R2: The slot index advances by one per cycle modulo 16. With no pairing or borrowing, a requesting core `s` is granted in slot `s`, and the result is visible one cycle after the slot.
- R3: At most one grant bit is high in any cycle. `grant_valid` is low and `grant_vec` is zero when no eligible core requests the slot.
- R4: When pair bit `p` is set and its shared bit is clear (simple pairing), core `p` is granted in slots `p` and `p+8` when it requests, and core `p+8` is never granted.
- R5: When pair bit `p` and shared bit `p` are both set, core `p` wins slots `p` and `p+8` when it requests. Otherwise core `p+8` wins them when it requests.
- R6: Borrow code 1 lends a slot to core 0 when the slot's owner is unpaired and idle. Codes 0 and 3 disable borrowing.
- R7: Borrow code 2 lends an idle unpaired owner's slot to core 0 only when the slot index is even, and to core 8 only when it is odd.
- R8: While pair 0 is enabled, cores 0 and 8 do not borrow. In any enabled pair, idle pair slots are never lent out.
- R9: An unpaired core that requests in its own slot is always granted that slot, whatever the other cores request.
- R10: A configuration write is captured at the clock edge where `cfg_we` is high. It governs arbitration from the next slot 0 onward, counting only wraps (slot 15 to slot 0) strictly after the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 16 | Per-core access request, bit i for core i |
| cfg_we | input | 1 | Strobe that writes the staging configuration |
| cfg_pair_en | input | 8 | Bit p enables pairing of cores p and p+8 |
| cfg_pair_shared | input | 8 | Bit p selects shared (1) or simple (0) pairing |
| cfg_mooch | input | 2 | Borrow mode: 0 off, 1 core 0 only, 2 even/odd split, 3 off |
| grant_vec | output | 16 | One-hot grant, registered |
| grant_idx | output | 4 | Index of the granted core, registered |
| grant_valid | output | 1 | A grant is present this cycle |

## Verification
The embedded properties assume that `core_req` is a level sampled once per clock. They also assume that the configuration inputs are only meaningful on cycles where `cfg_we` is high, so the active setting changes solely at a wrap. The own-slot determinism property relies on the registered copy of the active pair bits matching the slot in which the request was seen. The stimulus therefore changes `core_req` and the configuration only at falling edges. It issues writes at arbitrary slot positions, including just before a wrap, so the deferred-apply rule is exercised without glitching the inputs mid-cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    MOOCH_OFF    = 2'd0,
    MOOCH_SINGLE = 2'd1,
    MOOCH_SPLIT  = 2'd2,
    MOOCH_RSVD   = 2'd3
  } mooch_e;
endpackage

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int N = 16,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot,
  output logic          wrap
);
  localparam logic [SW-1:0] LAST = SW'(N - 1);

  assign wrap = (slot == LAST);

  always_ff @(posedge clk) begin
    if (rst)       slot <= '0;
    else if (wrap) slot <= '0;
    else           slot <= slot + 1'b1;
  end

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (slot == '0));
endmodule

// File: rtl/cfg_shadow.sv
module cfg_shadow
  import arb_pkg::*;
#(
  parameter int HALF = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic            wrap,
  input  logic [HALF-1:0] pair_in,
  input  logic [HALF-1:0] shared_in,
  input  logic [1:0]      mooch_in,
  output logic [HALF-1:0] act_pair,
  output logic [HALF-1:0] act_shared,
  output mooch_e          act_mooch
);
  logic [HALF-1:0] stg_pair, stg_shared;
  mooch_e          stg_mooch;

  for (genvar p = 0; p < HALF; p++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_pair[p]   <= 1'b0;
        stg_shared[p] <= 1'b0;
        act_pair[p]   <= 1'b0;
        act_shared[p] <= 1'b0;
      end else begin
        if (we) begin
          stg_pair[p]   <= pair_in[p];
          stg_shared[p] <= shared_in[p];
        end
        if (wrap) begin
          act_pair[p]   <= stg_pair[p];
          act_shared[p] <= stg_shared[p];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_mooch <= MOOCH_OFF;
      act_mooch <= MOOCH_OFF;
    end else begin
      if (we)   stg_mooch <= mooch_e'(mooch_in);
      if (wrap) act_mooch <= stg_mooch;
    end
  end

  // R10
  cfg_wrap_only_chk: assert property (@(posedge clk) disable iff (rst)
    ((act_pair != $past(act_pair)) || (act_mooch != $past(act_mooch))) |-> $past(wrap));
endmodule

// File: rtl/slot_resolver.sv
module slot_resolver
  import arb_pkg::*;
#(
  parameter int N = 16,
  localparam int SW = $clog2(N),
  localparam int HALF = N / 2
) (
  input  logic [SW-1:0]   slot,
  input  logic [N-1:0]    req,
  input  logic [HALF-1:0] pair_en,
  input  logic [HALF-1:0] shared,
  input  mooch_e          mooch,
  output logic            win_valid,
  output logic [SW-1:0]   win_idx
);
  localparam logic [SW-1:0] UPPER_BASE = SW'(HALF);

  logic [SW-2:0] pidx;
  logic [SW-1:0] lo, hi, borrower;
  logic          borrow_ok;

  always_comb begin
    pidx      = slot[SW-2:0];
    lo        = {1'b0, pidx};
    hi        = {1'b1, pidx};
    borrower  = ((mooch == MOOCH_SPLIT) && slot[0]) ? UPPER_BASE : '0;
    borrow_ok = ((mooch == MOOCH_SINGLE) || (mooch == MOOCH_SPLIT)) && !pair_en[0];
    win_valid = 1'b0;
    win_idx   = '0;
    if (pair_en[pidx]) begin
      if (req[lo]) begin
        win_valid = 1'b1;
        win_idx   = lo;
      end else if (shared[pidx] && req[hi]) begin
        win_valid = 1'b1;
        win_idx   = hi;
      end
    end else if (req[slot]) begin
      win_valid = 1'b1;
      win_idx   = slot;
    end else if (borrow_ok && req[borrower]) begin
      win_valid = 1'b1;
      win_idx   = borrower;
    end
  end
endmodule

// File: rtl/pair_slot_arbiter.sv
module pair_slot_arbiter
  import arb_pkg::*;
#(
  parameter int N = 16,
  localparam int SW = $clog2(N),
  localparam int HALF = N / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    core_req,
  input  logic            cfg_we,
  input  logic [HALF-1:0] cfg_pair_en,
  input  logic [HALF-1:0] cfg_pair_shared,
  input  logic [1:0]      cfg_mooch,
  output logic [N-1:0]    grant_vec,
  output logic [SW-1:0]   grant_idx,
  output logic            grant_valid
);
  logic [SW-1:0]   slot, win_idx;
  logic            wrap, win_valid;
  logic [HALF-1:0] act_pair, act_shared;
  mooch_e          act_mooch;

  slot_counter #(.N(N)) u_cnt (
    .clk(clk), .rst(rst), .slot(slot), .wrap(wrap));

  cfg_shadow #(.HALF(HALF)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wrap(wrap),
    .pair_in(cfg_pair_en), .shared_in(cfg_pair_shared), .mooch_in(cfg_mooch),
    .act_pair(act_pair), .act_shared(act_shared), .act_mooch(act_mooch));

  slot_resolver #(.N(N)) u_res (
    .slot(slot), .req(core_req), .pair_en(act_pair), .shared(act_shared),
    .mooch(act_mooch), .win_valid(win_valid), .win_idx(win_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_idx   <= '0;
      grant_vec   <= '0;
    end else begin
      grant_valid <= win_valid;
      grant_idx   <= win_idx;
      grant_vec   <= win_valid ? (N'(1) << win_idx) : '0;
    end
  end

  // Registered view of the conditions each grant was decided under
  logic [N-1:0]    req_d;
  logic [SW-1:0]   slot_d;
  logic [HALF-1:0] pair_d, shared_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d    <= '0;
      slot_d   <= '0;
      pair_d   <= '0;
      shared_d <= '0;
    end else begin
      req_d    <= core_req;
      slot_d   <= slot;
      pair_d   <= act_pair;
      shared_d <= act_shared;
    end
  end

  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_vec));

  // R3
  grant_had_req_chk: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> req_d[grant_idx]);

  // R9
  own_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (req_d[slot_d] && !pair_d[slot_d[SW-2:0]]) |-> (grant_valid && grant_idx == slot_d));

  // R4
  partner_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && grant_idx[SW-1]) |->
      !(pair_d[grant_idx[SW-2:0]] && !shared_d[grant_idx[SW-2:0]]));
endmodule

// File: tb/pair_slot_arbiter_test.sv
module pair_slot_arbiter_test;
  localparam int N = 16;
  localparam int HALF = 8;
  localparam int SW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    core_req = '0;
  logic            cfg_we = 1'b0;
  logic [HALF-1:0] cfg_pair_en = '0;
  logic [HALF-1:0] cfg_pair_shared = '0;
  logic [1:0]      cfg_mooch = '0;
  logic [N-1:0]    grant_vec;
  logic [SW-1:0]   grant_idx;
  logic            grant_valid;

  pair_slot_arbiter #(.N(N)) uut (
    .clk(clk), .rst(rst), .core_req(core_req), .cfg_we(cfg_we),
    .cfg_pair_en(cfg_pair_en), .cfg_pair_shared(cfg_pair_shared),
    .cfg_mooch(cfg_mooch), .grant_vec(grant_vec), .grant_idx(grant_idx),
    .grant_valid(grant_valid));

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  string tag = "R2";
  int    exp_q[$];
  string tag_q[$];

  // model state
  int mslot = 0;
  logic [HALF-1:0] m_pe = '0, m_sh = '0, s_pe = '0, s_sh = '0;
  int m_mm = 0, s_mm = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int expect_win(int s, logic [N-1:0] r);
    int p = s % HALF;
    int b = ((m_mm == 2) && (s % 2 == 1)) ? HALF : 0;
    if (m_pe[p]) begin
      if (r[p]) return p;
      if (m_sh[p] && r[p+HALF]) return p + HALF;
      return -1;
    end
    if (r[s]) return s;
    if ((m_mm == 1 || m_mm == 2) && !m_pe[0] && r[b]) return b;
    return -1;
  endfunction

  function automatic logic [15:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  // driver: applies inputs at a falling edge, records the expected grant
  task automatic step(input logic [N-1:0] r, input bit we);
    core_req = r;
    cfg_we   = we;
    exp_q.push_back(expect_win(mslot, r));
    tag_q.push_back(tag);
    if (mslot == N - 1) begin
      m_pe = s_pe; m_sh = s_sh; m_mm = s_mm;
    end
    if (we) begin
      s_pe = cfg_pair_en; s_sh = cfg_pair_shared; s_mm = int'(cfg_mooch);
    end
    mslot = (mslot + 1) % N;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_cfg(input logic [HALF-1:0] pe, input logic [HALF-1:0] sh,
                           input logic [1:0] mm, input logic [N-1:0] r);
    cfg_pair_en = pe; cfg_pair_shared = sh; cfg_mooch = mm;
    step(r, 1'b1);
  endtask

  task automatic run(input logic [N-1:0] r, input int n);
    for (int i = 0; i < n; i++) step(r, 1'b0);
  endtask

  task automatic run_rand(input int n);
    for (int i = 0; i < n; i++) step(next_rand(), 1'b0);
  endtask

  // monitor: compares the registered grant after each rising edge
  always @(posedge clk) begin
    #2;
    if (!rst && exp_q.size() > 0) begin
      int e;
      string t;
      logic [N-1:0] ev;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      ev = (e < 0) ? '0 : (N'(1) << e);
      compared++;
      if (grant_valid !== (e >= 0) || grant_vec !== ev ||
          (e >= 0 && grant_idx !== SW'(e))) begin
        mismatched++;
        $display("FAIL %s: got valid=%0b idx=%0d vec=%h, expected valid=%0b idx=%0d vec=%h",
                 t, grant_valid, grant_idx, grant_vec, (e >= 0), e, ev);
      end
    end
  end

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: got no completion, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs cleared while in reset
    compared++;
    if (grant_valid !== 1'b0 || grant_vec !== '0 || grant_idx !== '0) begin
      mismatched++;
      $display("FAIL R1: got valid=%0b vec=%h, expected 0 0", grant_valid, grant_vec);
    end
    rst = 1'b0;
    tag = "R1";
    // first slots after reset: default rotation, nothing paired or lent
    run(16'h0001, 2);
    tag = "R2";
    run(16'hFFFF, 16);
    run(16'h8421, 16);
    tag = "R3";
    run(16'h0000, 8);
    tag = "R9";
    run_rand(32);

    // R10: write mid rotation, must wait for the wrap
    tag = "R10";
    write_cfg(8'h01, 8'h00, 2'd0, 16'hFFFF);
    run(16'h0101, 20);
    tag = "R4";
    run(16'hFF00, 16);
    run(16'h0001, 16);
    run_rand(32);

    tag = "R5";
    write_cfg(8'h08, 8'h08, 2'd0, 16'h0808);
    run(16'h0808, 18);
    run(16'h0800, 16);
    run(16'hFF00, 16);
    run_rand(32);

    tag = "R6";
    write_cfg(8'h00, 8'h00, 2'd1, 16'h0001);
    run(16'h0001, 18);
    run(16'h0101, 16);
    run_rand(32);

    tag = "R7";
    write_cfg(8'h00, 8'h00, 2'd2, 16'h0101);
    run(16'h0101, 18);
    run(16'h0100, 16);
    run_rand(32);

    tag = "R8";
    write_cfg(8'h11, 8'h01, 2'd2, 16'h0101);
    run(16'h0101, 18);
    run(16'h0100, 16);
    run(16'h1000, 16);
    run_rand(32);

    tag = "R6";
    write_cfg(8'h00, 8'h00, 2'd3, 16'h0001);
    run(16'h0101, 20);

    // R10: write issued exactly in the last slot before a wrap
    tag = "R10";
    while (mslot != N - 1) step(16'h0001, 1'b0);
    write_cfg(8'h01, 8'h00, 2'd1, 16'h0101);
    run(16'h0101, 16);
    run(16'h0100, 18);

    @(posedge clk);
    #4;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule